// File: doc/BRIEF.md
# Software-Sequenced SPI Flash Command Engine

This block issues one SPI flash command each time software asks for one. Software loads a small register set first: an eight-entry table of opcode bytes, a two-bit kind for each entry, an optional prefix opcode, a 24-bit flash address and a data buffer. It then writes the control word with its start bit set. The engine drops chip select and shifts out the opcode selected by a three-bit index. When the entry's kind calls for it, the three address bytes follow, and then an optional data phase that either sends bytes from the buffer or collects bytes into it. When software asks for an atomic prefix, a separate one-byte command carrying the prefix opcode (typically write-enable) is sent first. Chip select rises between the prefix command and the main command and again after the main command, and no other access can run in that space.

Software polls a status word for busy, done and error. Done and error are cleared by writing ones to them. A sticky lock bit, which only reset clears, freezes the opcode table, the kind table and the prefix register. The serial link runs in mode 0. A control bit picks one of two serial clock rates for each command.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset spi_cs_n is 1, spi_sclk is 0, and the status word (offset 1) and control word (offset 0) read as 0.
- R2: A command starts when software writes 1 to control bit 0. Chip select then falls and the first byte sent is the opcode table entry chosen by control bits 6:4. Entries 0..3 are read at offset 3 and entries 4..7 at offset 4, one byte per entry with the lowest entry in bits 7:0. When bit 1 of the entry's 2-bit kind is set (kinds at offset 5, entry n in bits 2n+1:2n), address bits 23:16, 15:8 and 7:0 (offset 2) follow in that order.
- R3: When control bit 2 is set and kind bit 0 is 1 (write), the data phase sends (control bits 13:8)+1 bytes from the buffer in order. Buffer byte i sits in word 8+i/4, bits 8*(i%4)+7 down to 8*(i%4).
- R4: When control bit 2 is set and kind bit 0 is 0 (read), the same number of bytes is taken from spi_miso, most significant bit first, and stored in buffer bytes 0 upward at the same positions.
- R5: When control bit 2 is clear, there is no data phase, whatever the count field holds, and the buffer is not changed.
- R6: When control bit 1 is set and the prefix register (offset 6, bits 7:0) is non-zero, a one-byte command carrying the prefix opcode runs before the main command. When the prefix register is zero, only the main command runs.
- R7: Chip select stays high for at least two clock cycles after the prefix command and after the main command.
- R8: Status bit 0 (busy) is 1 while a command runs. Status bit 1 (done) is set when the command finishes. Writing 1 to bit 1 or to bit 2 of the status word clears that bit.
- R9: A start written while busy does not start a second command and sets status bit 2 (error).
- R10: A start with control bit 2 set and a byte count above the buffer size (DATA_BYTES) sets the error bit, and no command starts.
- R11: Writing 1 to status bit 3 sets the lock. Once locked, writes to offsets 3, 4, 5 and 6 have no effect until reset, and status bit 3 reads 1.
- R12: Control bit 16 selects the serial clock. Each SCLK high and low phase lasts HALF_FAST clock cycles when the bit is 1 and HALF_SLOW clock cycles when it is 0.
- R13: The link uses mode 0: SCLK idles low, spi_mosi changes only while SCLK is low, and SCLK stays low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | REG_AW | Register write word offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | REG_AW | Register read word offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
All eight table entries are run with their four kinds twice. The first pass uses rising byte counts on the slow clock and the second uses falling counts on the fast clock, so every count from 1 to the buffer size is used for both directions. Each command is compared with a flash model whose reply depends on the byte position. This separates the address phase from the data phase, shows byte order and bit order, and catches an off-by-one in the count. The SCLK high time is counted per command, which tells the two clock rates apart. Separate cases cover a prefix present and a prefix zero, a start written during a running command, a count one above the buffer size, a command with the data phase turned off and a large count field, and writes made after the lock is set.

// File: rtl/spi_eng_pkg.sv
// Shared definitions for the SPI command engine: register offsets,
// control/status bit positions, sequencer states and the launch record.
package spi_eng_pkg;

    // word offsets in the register window
    localparam int OFS_CTRL = 0;
    localparam int OFS_STAT = 1;
    localparam int OFS_ADDR = 2;
    localparam int OFS_MLO  = 3;
    localparam int OFS_MHI  = 4;
    localparam int OFS_KIND = 5;
    localparam int OFS_PFX  = 6;
    localparam int OFS_DATA = 8;

    // control word bit positions
    localparam int CTRL_GO   = 0;
    localparam int CTRL_ATOM = 1;
    localparam int CTRL_DEN  = 2;
    localparam int CTRL_SPD  = 16;
    localparam logic [31:0] CTRL_KEEP = 32'h0001_3F76;

    // status word bit positions
    localparam int STAT_BUSY = 0;
    localparam int STAT_DONE = 1;
    localparam int STAT_ERR  = 2;
    localparam int STAT_LOCK = 3;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_PRE, SQ_PGAP, SQ_OP, SQ_ADR, SQ_DAT, SQ_EGAP
    } seq_state_t;

    // everything the sequencer needs, captured at the start of a command
    typedef struct packed {
        logic [7:0]  opcode;
        logic [1:0]  kind;     // bit1: address phase, bit0: write direction
        logic [7:0]  prefix;
        logic        use_pre;
        logic        den;
        logic [6:0]  nbytes;
        logic        fast;
        logic [23:0] addr;
    } launch_t;

endpackage

// File: rtl/spi_eng_shift.sv
// Mode-0 byte shifter. On start it loads one byte and runs eight SCLK periods.
// Each phase lasts HALF_FAST or HALF_SLOW clocks, chosen by 'fast'. MOSI is
// updated only after a falling edge. MISO is sampled at the clock where SCLK
// rises. 'done' pulses for one cycle after the last falling edge.
// Assumes 'fast' is steady while a byte is in flight and start only when idle.
module spi_eng_shift #(
    parameter int HALF_SLOW = 3,
    parameter int HALF_FAST = 2,
    localparam int HMAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST,
    localparam int HW   = $clog2(HMAX + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       fast,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi
);
    logic          active;
    logic          sclk_q;
    logic [HW-1:0] hcnt;
    logic [2:0]    bcnt;
    logic [7:0]    tx_q;
    logic [7:0]    rx_q;
    logic [HW-1:0] half_lim;

    // phase length for the current byte
    assign half_lim = fast ? HW'(HALF_FAST - 1) : HW'(HALF_SLOW - 1);

    // bit timing, shifting and sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            sclk_q <= 1'b0;
            hcnt   <= '0;
            bcnt   <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    tx_q   <= tx_byte;
                    hcnt   <= '0;
                    bcnt   <= '0;
                    sclk_q <= 1'b0;
                end
            end else if (hcnt == half_lim) begin
                hcnt <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    if (bcnt == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bcnt <= bcnt + 3'd1;
                        tx_q <= {tx_q[6:0], 1'b0};
                    end
                end
            end else begin
                hcnt <= hcnt + HW'(1);
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = active ? tx_q[7] : 1'b0;
    assign rx_byte = rx_q;

    // R13: data toward the flash holds still through each high phase
    assert_mosi_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sclk_q) && sclk_q) |-> $stable(mosi));

endmodule

// File: rtl/spi_eng_seq.sv
// Command sequencer. It takes a launch record and walks the phases: optional
// prefix byte, chip-select gap, opcode, optional three address bytes, optional
// data bytes, closing gap. It feeds bytes to the shifter, returns read bytes
// to the buffer and raises 'finish' in the last gap cycle.
// Assumes GAP_CLKS >= 2 and nbytes >= 1 whenever den is set.
module spi_eng_seq
    import spi_eng_pkg::*;
#(
    parameter int DATA_BYTES = 64,
    parameter int GAP_CLKS   = 2,
    localparam int IDX_W = $clog2(DATA_BYTES),
    localparam int GW    = $clog2(GAP_CLKS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  launch_t          cmd,
    input  logic             sh_done,
    input  logic [7:0]       sh_rx,
    input  logic [7:0]       buf_byte,
    output logic             sh_start,
    output logic [7:0]       sh_tx,
    output logic             fast,
    output logic             cs_n,
    output logic             busy,
    output logic             finish,
    output logic [IDX_W-1:0] buf_idx,
    output logic             rx_we,
    output logic [7:0]       rx_byte
);
    seq_state_t    state;
    launch_t       cmd_q;
    logic          inflight;
    logic [6:0]    bidx;
    logic [GW-1:0] gcnt;
    logic          byte_phase;
    logic          byte_end;
    logic          gap_end;

    assign byte_phase = (state == SQ_PRE) || (state == SQ_OP) ||
                        (state == SQ_ADR) || (state == SQ_DAT);
    assign byte_end   = byte_phase && inflight && sh_done;
    assign gap_end    = (gcnt == GW'(GAP_CLKS - 1));

    // phase walk and per-phase counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            cmd_q    <= '0;
            inflight <= 1'b0;
            bidx     <= '0;
            gcnt     <= '0;
        end else begin
            if (byte_phase && !inflight) inflight <= 1'b1;
            if (byte_end) inflight <= 1'b0;
            case (state)
                SQ_IDLE: if (launch) begin
                    cmd_q <= cmd;
                    bidx  <= '0;
                    state <= cmd.use_pre ? SQ_PRE : SQ_OP;
                end
                SQ_PRE: if (byte_end) begin
                    gcnt  <= '0;
                    state <= SQ_PGAP;
                end
                SQ_PGAP: begin
                    gcnt <= gcnt + GW'(1);
                    if (gap_end) state <= SQ_OP;
                end
                SQ_OP: if (byte_end) begin
                    bidx <= '0;
                    gcnt <= '0;
                    if (cmd_q.kind[1])  state <= SQ_ADR;
                    else if (cmd_q.den) state <= SQ_DAT;
                    else                state <= SQ_EGAP;
                end
                SQ_ADR: if (byte_end) begin
                    if (bidx == 7'd2) begin
                        bidx  <= '0;
                        state <= cmd_q.den ? SQ_DAT : SQ_EGAP;
                    end else begin
                        bidx <= bidx + 7'd1;
                    end
                end
                SQ_DAT: if (byte_end) begin
                    if (bidx == cmd_q.nbytes - 7'd1) state <= SQ_EGAP;
                    else bidx <= bidx + 7'd1;
                end
                SQ_EGAP: begin
                    gcnt <= gcnt + GW'(1);
                    if (gap_end) state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // byte offered to the shifter in each phase
    always_comb begin
        case (state)
            SQ_PRE:  sh_tx = cmd_q.prefix;
            SQ_OP:   sh_tx = cmd_q.opcode;
            SQ_ADR: begin
                case (bidx[1:0])
                    2'd0:    sh_tx = cmd_q.addr[23:16];
                    2'd1:    sh_tx = cmd_q.addr[15:8];
                    default: sh_tx = cmd_q.addr[7:0];
                endcase
            end
            SQ_DAT:  sh_tx = cmd_q.kind[0] ? buf_byte : 8'h00;
            default: sh_tx = 8'h00;
        endcase
    end

    assign sh_start = byte_phase && !inflight;
    assign fast     = cmd_q.fast;
    assign cs_n     = !byte_phase;
    assign busy     = (state != SQ_IDLE);
    assign finish   = (state == SQ_EGAP) && gap_end;
    assign buf_idx  = bidx[IDX_W-1:0];
    assign rx_we    = (state == SQ_DAT) && byte_end && !cmd_q.kind[0];
    assign rx_byte  = sh_rx;

    // R9: a start is only accepted by an idle sequencer
    assert_launch_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (state == SQ_IDLE));

    // R5: no data phase is entered when the data enable was clear
    assert_no_data_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_DAT) |-> cmd_q.den);

endmodule

// File: rtl/spi_eng_regs.sv
// Register window: control, status (busy/done/error/lock), address, opcode
// table, kind table, prefix and the data buffer. It checks a start request
// and builds the launch record from the control word being written and the
// stored registers. While busy, the buffer, address and control stay steady.
// Assumes DATA_BYTES is a multiple of 4 and fits the window size REG_AW.
module spi_eng_regs
    import spi_eng_pkg::*;
#(
    parameter int DATA_BYTES = 64,
    parameter int REG_AW     = 5,
    localparam int IDX_W = $clog2(DATA_BYTES),
    localparam int WORDS = DATA_BYTES / 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              busy,
    input  logic              finish,
    input  logic [IDX_W-1:0]  buf_idx,
    input  logic              rx_we,
    input  logic [7:0]        rx_byte,
    output logic [7:0]        buf_byte,
    output logic              launch,
    output launch_t           cmd
);
    logic [7:0]  menu_q [8];
    logic [15:0] kind_q;
    logic [7:0]  pfx_q;
    logic [23:0] addr_q;
    logic [31:0] ctrl_q;
    logic        lock_q, done_q, err_q;
    logic [7:0]  buf_w [DATA_BYTES];

    logic        hit_ctrl, hit_stat, go, bad_cnt;
    logic [2:0]  sel;
    logic [6:0]  cnt;

    assign hit_ctrl = wr_en && (wr_addr == REG_AW'(OFS_CTRL));
    assign hit_stat = wr_en && (wr_addr == REG_AW'(OFS_STAT));
    assign go       = hit_ctrl && wr_data[CTRL_GO];
    assign sel      = wr_data[6:4];
    assign cnt      = {1'b0, wr_data[13:8]} + 7'd1;
    assign bad_cnt  = wr_data[CTRL_DEN] && (cnt > 7'(DATA_BYTES));
    assign launch   = go && !busy && !bad_cnt;

    // launch record from the incoming control word and stored registers
    always_comb begin
        cmd.opcode  = menu_q[sel];
        cmd.kind    = kind_q[{sel, 1'b0} +: 2];
        cmd.prefix  = pfx_q;
        cmd.use_pre = wr_data[CTRL_ATOM] && (pfx_q != 8'h00);
        cmd.den     = wr_data[CTRL_DEN];
        cmd.nbytes  = cnt;
        cmd.fast    = wr_data[CTRL_SPD];
        cmd.addr    = addr_q;
    end

    // lockable command tables and prefix
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) menu_q[i] <= 8'h00;
            kind_q <= '0;
            pfx_q  <= '0;
        end else if (wr_en && !lock_q) begin
            if (wr_addr == REG_AW'(OFS_MLO))
                for (int i = 0; i < 4; i++) menu_q[i] <= wr_data[8*i +: 8];
            if (wr_addr == REG_AW'(OFS_MHI))
                for (int i = 0; i < 4; i++) menu_q[i+4] <= wr_data[8*i +: 8];
            if (wr_addr == REG_AW'(OFS_KIND)) kind_q <= wr_data[15:0];
            if (wr_addr == REG_AW'(OFS_PFX))  pfx_q  <= wr_data[7:0];
        end
    end

    // address and stored control fields, frozen while a command runs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            ctrl_q <= '0;
        end else if (wr_en && !busy) begin
            if (wr_addr == REG_AW'(OFS_ADDR)) addr_q <= wr_data[23:0];
            if (hit_ctrl) ctrl_q <= wr_data & CTRL_KEEP;
        end
    end

    // status flags: sticky lock, done and error with write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (hit_stat && wr_data[STAT_LOCK]) lock_q <= 1'b1;
            if (finish) done_q <= 1'b1;
            else if (hit_stat && wr_data[STAT_DONE]) done_q <= 1'b0;
            if (go && (busy || bad_cnt)) err_q <= 1'b1;
            else if (hit_stat && wr_data[STAT_ERR]) err_q <= 1'b0;
        end
    end

    // data buffer, one register per byte
    for (genvar b = 0; b < DATA_BYTES; b++) begin : g_byte
        localparam int WSEL = OFS_DATA + b / 4;
        localparam int LSB  = 8 * (b % 4);
        logic [7:0] byte_q;
        // engine read data has priority; software writes only when idle
        always_ff @(posedge clk) begin
            if (!rst_n) byte_q <= 8'h00;
            else if (rx_we && (buf_idx == IDX_W'(b))) byte_q <= rx_byte;
            else if (wr_en && !busy && (wr_addr == REG_AW'(WSEL)))
                byte_q <= wr_data[LSB +: 8];
        end
        assign buf_w[b] = byte_q;
    end

    assign buf_byte = buf_w[buf_idx];

    // register read mux
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_AW'(OFS_CTRL): rd_data = ctrl_q;
            REG_AW'(OFS_STAT): rd_data = {28'd0, lock_q, err_q, done_q, busy};
            REG_AW'(OFS_ADDR): rd_data = {8'd0, addr_q};
            REG_AW'(OFS_MLO):  rd_data = {menu_q[3], menu_q[2], menu_q[1], menu_q[0]};
            REG_AW'(OFS_MHI):  rd_data = {menu_q[7], menu_q[6], menu_q[5], menu_q[4]};
            REG_AW'(OFS_KIND): rd_data = {16'd0, kind_q};
            REG_AW'(OFS_PFX):  rd_data = {24'd0, pfx_q};
            default: begin
                for (int w = 0; w < WORDS; w++)
                    if (rd_addr == REG_AW'(OFS_DATA + w))
                        rd_data = {buf_w[4*w+3], buf_w[4*w+2], buf_w[4*w+1], buf_w[4*w]};
            end
        endcase
    end

    // R9: start while busy raises the error flag
    assert_busy_go_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (go && busy) |=> err_q);

    // R10: an oversize count leaves the sequencer idle
    assert_oversize_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (go && bad_cnt && !busy) |=> !busy);

    // R11: the lock never falls without reset
    assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    // R8: done only rises at the end of a running command
    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(busy));

endmodule

// File: rtl/spi_cmd_engine.sv
// Top of the SPI command engine: register window, sequencer and mode-0
// byte shifter. Timing parameters are in system clock cycles.
// Assumes DATA_BYTES is a multiple of 4 with 8+DATA_BYTES/4 <= 2**REG_AW.
module spi_cmd_engine
    import spi_eng_pkg::*;
#(
    parameter int DATA_BYTES = 64,
    parameter int REG_AW     = 5,
    parameter int HALF_SLOW  = 3,
    parameter int HALF_FAST  = 2,
    parameter int GAP_CLKS   = 2,
    localparam int IDX_W = $clog2(DATA_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_waddr,
    input  logic [31:0]       reg_wdata,
    input  logic [REG_AW-1:0] reg_raddr,
    output logic [31:0]       reg_rdata,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic             busy, finish, launch, rx_we;
    logic             sh_start, sh_done, fast;
    logic [7:0]       sh_tx, sh_rx, buf_byte, rx_byte;
    logic [IDX_W-1:0] buf_idx;
    launch_t          cmd;

    spi_eng_regs #(.DATA_BYTES(DATA_BYTES), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr), .wr_addr(reg_waddr), .wr_data(reg_wdata),
        .rd_addr(reg_raddr), .rd_data(reg_rdata),
        .busy(busy), .finish(finish),
        .buf_idx(buf_idx), .rx_we(rx_we), .rx_byte(rx_byte),
        .buf_byte(buf_byte), .launch(launch), .cmd(cmd)
    );

    spi_eng_seq #(.DATA_BYTES(DATA_BYTES), .GAP_CLKS(GAP_CLKS)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .cmd(cmd),
        .sh_done(sh_done), .sh_rx(sh_rx), .buf_byte(buf_byte),
        .sh_start(sh_start), .sh_tx(sh_tx), .fast(fast),
        .cs_n(spi_cs_n), .busy(busy), .finish(finish),
        .buf_idx(buf_idx), .rx_we(rx_we), .rx_byte(rx_byte)
    );

    spi_eng_shift #(.HALF_SLOW(HALF_SLOW), .HALF_FAST(HALF_FAST)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start(sh_start), .fast(fast), .tx_byte(sh_tx), .miso(spi_miso),
        .done(sh_done), .rx_byte(sh_rx), .sclk(spi_sclk), .mosi(spi_mosi)
    );

    // R13: the serial clock rests low whenever the flash is deselected
    assert_sclk_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R7: once raised, chip select stays high for at least a second cycle
    assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> spi_cs_n);

endmodule

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
module spi_cmd_engine_bench;
    localparam int DB = 8;
    localparam int AW = 4;
    localparam int HS = 3;
    localparam int HF = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_waddr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [AW-1:0] reg_raddr = '0;
    logic [31:0]   reg_rdata;
    logic          spi_cs_n, spi_sclk, spi_mosi;
    logic          miso_r = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    spi_cmd_engine #(.DATA_BYTES(DB), .REG_AW(AW), .HALF_SLOW(HS),
                     .HALF_FAST(HF), .GAP_CLKS(2)) u_spi_cmd_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(miso_r)
    );

    // flash model: logs bytes, chip-select gaps and SCLK high time per command
    logic [7:0] log_b [64][16];
    int log_len [64];
    int gaps [64];
    int hi_cnt [64];
    int ntr = 0;
    int nb, ib, ob, obit, hc, gap_run;
    logic [7:0] cur;
    logic prev_cs = 1'b1, prev_sclk = 1'b0;

    function automatic logic [7:0] resp(input int tr, input int k);
        return 8'((k * 37) + (tr * 11) + 5);
    endfunction

    always @(negedge clk) begin
        logic [7:0] rb;
        if (!rst_n) begin
            prev_cs = 1'b1; prev_sclk = 1'b0; gap_run = 100;
        end else begin
            if (spi_cs_n) begin
                if (!prev_cs) begin
                    log_len[ntr] = nb; hi_cnt[ntr] = hc;
                    if (ntr < 63) ntr++;
                end
                gap_run++;
            end else begin
                if (prev_cs) begin
                    gaps[ntr] = gap_run; gap_run = 0;
                    nb = 0; ib = 0; ob = 0; obit = 0; hc = 0; cur = 0;
                    rb = resp(ntr, 0); miso_r = rb[7];
                end
                if (spi_sclk) hc++;
                if (spi_sclk && !prev_sclk) begin
                    cur = {cur[6:0], spi_mosi}; ib++;
                    if (ib == 8) begin
                        if (nb < 16) log_b[ntr][nb] = cur;
                        nb++; ib = 0;
                    end
                end
                if (!spi_sclk && prev_sclk) begin
                    obit++;
                    if (obit == 8) begin obit = 0; ob++; end
                    rb = resp(ntr, ob); miso_r = rb[7-obit];
                end
            end
            prev_cs = spi_cs_n; prev_sclk = spi_sclk;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_raddr = AW'(a);
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        int n = 0;
        do begin rd(1, s); n++; end while (s[0] && n < 5000);
    endtask

    function automatic logic [31:0] ctrl(input int idx, input bit den, input int cnt,
                                         input bit atom, input bit fst);
        return 32'(1 | (int'(atom) << 1) | (int'(den) << 2) | (idx << 4) |
                   (((cnt - 1) & 63) << 8) | (int'(fst) << 16));
    endfunction

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, d2;
        int t0, len, cnt, kind, mism, hp;
        logic [23:0] ad;
        logic [7:0] exp_b;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(1, d); chk(d == 0, "R1 status", d, 0);
        rd(0, d); chk(d == 0, "R1 control", d, 0);
        chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1 pins", {spi_cs_n, spi_sclk}, 2);

        // program tables: opcode n = 0x03 + 0x20*n, kinds 0,1,2,3 repeating
        wr(3, 32'h6343_2303);
        wr(4, 32'hE3C3_A383);
        wr(5, 32'h0000_E4E4);
        rd(3, d); chk(d == 32'h6343_2303, "R2 table readback", d, 32'h63432303);

        // R2 R3 R4 R12: sweep every entry, both directions, all counts, both rates
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 8; i++) begin
                cnt = (p == 1) ? 8 - i : i + 1;
                kind = i % 4;
                hp = (p == 1) ? HF : HS;
                ad = 24'h123456 + 24'(i) * 24'h010203 + 24'(p);
                wr(2, {8'h00, ad});
                for (int w = 0; w < 2; w++) begin
                    d = '0;
                    for (int k = 0; k < 4; k++) d[8*k +: 8] = 8'((4*w + k) * 13 + i + p * 50);
                    wr(8 + w, d);
                end
                t0 = ntr;
                wr(0, ctrl(i, 1'b1, cnt, 1'b0, p[0]));
                if (p == 0 && i == 0) begin
                    rd(1, d); chk(d[0] == 1'b1, "R8 busy while running", d, 1);
                end
                wait_idle();
                rd(1, d);
                chk(d[1] == 1'b1 && d[2] == 1'b0, "R8 done set", d, 2);
                wr(1, 32'h2);
                rd(1, d); chk(d[1] == 1'b0, "R8 done cleared", d, 0);
                chk(ntr == t0 + 1, "R2 one command", ntr - t0, 1);
                len = 1 + ((kind >= 2) ? 3 : 0) + cnt;
                chk(log_len[t0] == len, "R2 byte count", log_len[t0], len);
                exp_b = 8'h03 + 8'(32 * i);
                chk(log_b[t0][0] == exp_b, "R2 opcode", log_b[t0][0], exp_b);
                if (kind >= 2) begin
                    chk({log_b[t0][1], log_b[t0][2], log_b[t0][3]} == ad,
                        "R2 address order", {log_b[t0][1], log_b[t0][2], log_b[t0][3]}, ad);
                end
                mism = 0;
                if (kind % 2 == 1) begin
                    for (int j = 0; j < cnt; j++)
                        if (log_b[t0][len - cnt + j] != 8'(j * 13 + i + p * 50)) mism++;
                    chk(mism == 0, "R3 write data", mism, 0);
                end else begin
                    rd(8, d); rd(9, d2);
                    for (int j = 0; j < cnt; j++) begin
                        exp_b = resp(t0, len - cnt + j);
                        if ((j < 4 ? d[8*j +: 8] : d2[8*(j-4) +: 8]) != exp_b) mism++;
                    end
                    chk(mism == 0, "R4 read data", mism, 0);
                end
                chk(hi_cnt[t0] == len * 8 * hp, "R12 sclk high time", hi_cnt[t0], len * 8 * hp);
            end
        end

        // R5: data enable clear, count field at maximum, read kind with address
        rd(8, d2);
        t0 = ntr;
        wr(0, ctrl(2, 1'b0, 64, 1'b0, 1'b0));
        wait_idle();
        chk(log_len[t0] == 4, "R5 no data phase", log_len[t0], 4);
        rd(8, d); chk(d == d2, "R5 buffer untouched", d, d2);
        wr(1, 32'h6);

        // R6 R7: atomic prefix ahead of a write-with-address command
        wr(6, 32'h06);
        t0 = ntr;
        wr(0, ctrl(3, 1'b1, 2, 1'b1, 1'b0));
        wait_idle();
        chk(ntr == t0 + 2, "R6 two commands", ntr - t0, 2);
        chk(log_len[t0] == 1 && log_b[t0][0] == 8'h06, "R6 prefix byte", log_b[t0][0], 6);
        chk(log_b[t0+1][0] == 8'h63 && log_len[t0+1] == 6, "R6 main after prefix",
            log_b[t0+1][0], 8'h63);
        chk(gaps[t0+1] >= 2, "R7 gap after prefix", gaps[t0+1], 2);
        wr(1, 32'h6);

        // R7: gap after the main command, before the next one
        t0 = ntr;
        wr(0, ctrl(1, 1'b0, 1, 1'b0, 1'b0));
        wait_idle();
        chk(gaps[t0] >= 2, "R7 gap after main", gaps[t0], 2);

        // R6: zero prefix means no prefix command even with atomic set
        wr(6, 32'h00);
        t0 = ntr;
        wr(0, ctrl(1, 1'b0, 1, 1'b1, 1'b0));
        wait_idle();
        chk(ntr == t0 + 1, "R6 zero prefix skipped", ntr - t0, 1);
        wr(1, 32'h6);

        // R9: start written while busy
        t0 = ntr;
        wr(0, ctrl(1, 1'b1, 8, 1'b0, 1'b0));
        wr(0, ctrl(0, 1'b1, 8, 1'b0, 1'b0));
        wait_idle();
        rd(1, d);
        chk(d[2] == 1'b1, "R9 error on busy start", d, 4);
        chk(ntr == t0 + 1, "R9 second start ignored", ntr - t0, 1);
        wr(1, 32'h4);
        rd(1, d); chk(d[2] == 1'b0, "R8 error cleared", d, 0);
        wr(1, 32'h2);

        // R10: one byte above the buffer size
        t0 = ntr;
        wr(0, ctrl(1, 1'b1, DB + 1, 1'b0, 1'b0));
        repeat (10) @(negedge clk);
        rd(1, d);
        chk(d[2] == 1'b1 && d[0] == 1'b0, "R10 oversize error", d, 4);
        chk(ntr == t0, "R10 no command", ntr - t0, 0);
        wr(1, 32'h4);

        // R11: lock freezes tables and prefix
        wr(6, 32'h21);
        wr(1, 32'h8);
        rd(1, d); chk(d[3] == 1'b1, "R11 lock bit", d, 8);
        wr(3, 32'hFFFF_FFFF);
        wr(4, 32'h0);
        wr(5, 32'h0);
        wr(6, 32'h55);
        rd(3, d); chk(d == 32'h6343_2303, "R11 table low frozen", d, 32'h63432303);
        rd(4, d); chk(d == 32'hE3C3_A383, "R11 table high frozen", d, 32'hE3C3A383);
        rd(5, d); chk(d == 32'hE4E4, "R11 kinds frozen", d, 32'hE4E4);
        rd(6, d); chk(d == 32'h21, "R11 prefix frozen", d, 32'h21);
        t0 = ntr;
        wr(0, ctrl(3, 1'b0, 1, 1'b0, 1'b0));
        wait_idle();
        chk(log_b[t0][0] == 8'h63 && log_len[t0] == 4, "R11 locked opcode used",
            log_b[t0][0], 8'h63);

        // R13: idle pins after all commands
        chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R13 idle pins", {spi_cs_n, spi_sclk}, 2);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule